// File: doc/BRIEF.md
# Multicycle Load-Store Processor Core

This block is a compact 32-bit processor core that executes one instruction at a time and spreads each instruction across several clock cycles. A single adder/logic unit and a single memory port serve every step: the same arithmetic unit advances the program counter, forms the branch target, computes load/store addresses and performs register-to-register operations, and the same memory port returns both instruction words and data words. Intermediate values are held in internal registers (instruction word, two operand latches, an arithmetic result latch and a memory data latch) between the steps.

A control state machine walks each instruction through fetch, decode with operand read, then an instruction-dependent sequence. Branch-if-equal completes in 3 cycles, register-register operations and stores in 4, and loads in 5. The branch target is computed during decode in case the instruction turns out to be a branch. The memory read is combinational: read data must reflect the address within the same cycle, and a write lands at the clock edge that ends the cycle in which the write enable is high. The program counter and a one-cycle completion pulse are exposed for observation.

Instruction fields: opcode bits [31:26], first source [25:21], second source/load target [20:16], destination [15:11], function code [5:0], 16-bit immediate [15:0].

Top module: `mc_core`

## Requirements
- R1: A synchronous reset clears the program counter to 0 and puts the control in its fetch step; during and right after reset the memory write enable and the completion pulse are low and the memory address equals 0.
- R2: In the fetch step the memory address equals the program counter, the returned word is latched as the instruction, and the program counter becomes its old value plus 4 at the end of that cycle; the program counter stays a multiple of 4.
- R3: Counted from its fetch cycle, a load word (opcode 0x23) takes 5 cycles, a store word (0x2B) and a register-register operation (opcode 0x00) take 4, a branch-if-equal (0x04) takes 3, and any other opcode takes 2.
- R4: A register-register instruction writes into the destination register the result selected by its function code: 0x20 add, 0x22 subtract, 0x24 bitwise AND, 0x25 bitwise OR, 0x2A signed set-less-than (1 or 0); add and subtract wrap modulo 2^32.
- R5: A load word writes into register [20:16] the memory word at the byte address register[25:21] plus the sign-extended immediate, including negative immediates.
- R6: A store word writes register [20:16] to the byte address register[25:21] plus the sign-extended immediate, with the write enable high for exactly one cycle, the cycle right after address computation.
- R7: A branch-if-equal whose two source registers match sets the program counter to (address of the branch + 4) + (sign-extended immediate × 4); when they differ the program counter is the address of the branch + 4.
- R8: Register 0 always reads as zero; register-register results and loads aimed at it are discarded.
- R9: An unrecognised opcode changes no register and no memory word and returns to fetch after its decode step.
- R10: The completion output is high for exactly one cycle, in the last cycle of each instruction, and the next cycle is a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| memAddr | output | 32 | Byte address to memory (program counter in fetch, computed address in data steps) |
| memWdata | output | 32 | Store data |
| memWe | output | 1 | Memory write enable, write occurs at the clock edge |
| memRdata | input | 32 | Read data, valid combinationally for the current address |
| pcOut | output | 32 | Current program counter |
| retired | output | 1 | One-cycle pulse in the final cycle of each instruction |

## Verification
On every cycle the assertions check the control sequencing: reset lands in fetch with a zero program counter, every fetch is followed by decode with the program counter advanced by 4, the program counter never moves outside fetch and branch steps and stays word aligned, a write only follows an address computation, a branch step is reached only through fetch and decode, and every completion pulse is followed by a fetch. The values that reach registers and memory — arithmetic results, effective addresses with negative offsets, discarded writes to register 0, the lack of side effects of an unknown opcode — and the exact per-instruction cycle counts and branch targets only show up in the bench's programs, which observe them through stores, the program counter and the completion pulse.

// File: rtl/mc_pkg.sv
package mc_pkg;

  localparam int XLEN    = 32;
  localparam int RIDX_W  = 5;
  localparam int REG_CNT = 1 << RIDX_W;
  localparam int OPC_W   = 6;
  localparam int FN_W    = 6;
  localparam int IMM_W   = 16;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    S_FETCH,
    S_DECODE,
    S_ADDR,
    S_EXEC,
    S_BRANCH,
    S_MEMRD,
    S_MEMWR,
    S_RDONE,
    S_LDONE
  } stateT;

  typedef enum logic [1:0] {
    SRCB_REG,
    SRCB_FOUR,
    SRCB_IMM,
    SRCB_IMMSH
  } srcBT;

  typedef enum logic [1:0] {
    ACTL_ADD,
    ACTL_SUB,
    ACTL_FUNCT
  } aluCtlT;

  typedef enum logic [2:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_AND,
    ALU_OR,
    ALU_SLT
  } aluOpT;

  typedef struct packed {
    logic   irLoad;
    logic   pcLoad;
    logic   pcLoadIfEq;
    logic   addrFromAlu;
    logic   memWrite;
    logic   regWrite;
    logic   dstIsRd;
    logic   wbFromMdr;
    logic   srcAIsReg;
    srcBT   srcB;
    aluCtlT aluCtl;
    logic   retire;
  } ctrlT;

endpackage

// File: rtl/mc_alu.sv
module mc_alu
  import mc_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  aluOpT             op,
  output logic [DATA_W-1:0] result,
  output logic              isZero
);

  logic signedLess;

  assign signedLess = $signed(opA) < $signed(opB);

  always_comb begin
    case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_AND: result = opA & opB;
      ALU_OR:  result = opA | opB;
      ALU_SLT: result = {{(DATA_W-1){1'b0}}, signedLess};
      default: result = opA + opB;
    endcase
  end

  assign isZero = (result == '0);

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int ENTRIES = REG_CNT
) (
  input  logic                       clk,
  input  logic [$clog2(ENTRIES)-1:0] rdAddrA,
  input  logic [$clog2(ENTRIES)-1:0] rdAddrB,
  output logic [DATA_W-1:0]          rdDataA,
  output logic [DATA_W-1:0]          rdDataB,
  input  logic                       wrEn,
  input  logic [$clog2(ENTRIES)-1:0] wrAddr,
  input  logic [DATA_W-1:0]          wrData
);

  localparam int AW = $clog2(ENTRIES);

  logic [DATA_W-1:0] regs [ENTRIES];

  always_ff @(posedge clk) begin
    if (wrEn && (wrAddr != '0)) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdDataA = (rdAddrA == AW'(0)) ? '0 : regs[rdAddrA];
  assign rdDataB = (rdAddrB == AW'(0)) ? '0 : regs[rdAddrB];

endmodule

// File: rtl/mc_control.sv
module mc_control
  import mc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output ctrlT             ctrl,
  output stateT            state
);

  stateT stateNext;
  logic  knownOp;
  logic  memOp;

  assign memOp   = (opcode == OPC_LOAD) || (opcode == OPC_STORE);
  assign knownOp = memOp || (opcode == OPC_RTYPE) || (opcode == OPC_BEQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_FETCH;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = S_FETCH;
    case (state)
      S_FETCH:  stateNext = S_DECODE;
      S_DECODE: begin
        if (memOp)                    stateNext = S_ADDR;
        else if (opcode == OPC_RTYPE) stateNext = S_EXEC;
        else if (opcode == OPC_BEQ)   stateNext = S_BRANCH;
        else                          stateNext = S_FETCH;
      end
      S_ADDR:   stateNext = (opcode == OPC_LOAD) ? S_MEMRD : S_MEMWR;
      S_MEMRD:  stateNext = S_LDONE;
      S_EXEC:   stateNext = S_RDONE;
      default:  stateNext = S_FETCH;
    endcase
  end

  always_comb begin
    ctrl = '0;
    ctrl.srcB   = SRCB_REG;
    ctrl.aluCtl = ACTL_ADD;
    case (state)
      S_FETCH: begin
        ctrl.irLoad = 1'b1;
        ctrl.pcLoad = 1'b1;
        ctrl.srcB   = SRCB_FOUR;
      end
      S_DECODE: begin
        ctrl.srcB   = SRCB_IMMSH;
        ctrl.retire = !knownOp;
      end
      S_ADDR: begin
        ctrl.srcAIsReg = 1'b1;
        ctrl.srcB      = SRCB_IMM;
      end
      S_EXEC: begin
        ctrl.srcAIsReg = 1'b1;
        ctrl.aluCtl    = ACTL_FUNCT;
      end
      S_BRANCH: begin
        ctrl.srcAIsReg  = 1'b1;
        ctrl.aluCtl     = ACTL_SUB;
        ctrl.pcLoadIfEq = 1'b1;
        ctrl.retire     = 1'b1;
      end
      S_MEMRD: begin
        ctrl.addrFromAlu = 1'b1;
      end
      S_MEMWR: begin
        ctrl.addrFromAlu = 1'b1;
        ctrl.memWrite    = 1'b1;
        ctrl.retire      = 1'b1;
      end
      S_RDONE: begin
        ctrl.regWrite = 1'b1;
        ctrl.dstIsRd  = 1'b1;
        ctrl.retire   = 1'b1;
      end
      S_LDONE: begin
        ctrl.regWrite  = 1'b1;
        ctrl.wbFromMdr = 1'b1;
        ctrl.retire    = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
  import mc_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlT              ctrl,
  output logic [OPC_W-1:0]  opcode,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] pc
);

  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] aQ;
  logic [DATA_W-1:0] bQ;
  logic [DATA_W-1:0] aluOutQ;
  logic [DATA_W-1:0] mdrQ;

  logic [DATA_W-1:0] rfA;
  logic [DATA_W-1:0] rfB;
  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] immShifted;
  logic [DATA_W-1:0] srcAVal;
  logic [DATA_W-1:0] srcBVal;
  logic [DATA_W-1:0] aluY;
  logic              aluZero;
  aluOpT             aluOp;

  logic [RIDX_W-1:0] fieldRs;
  logic [RIDX_W-1:0] fieldRt;
  logic [RIDX_W-1:0] fieldRd;
  logic [FN_W-1:0]   fieldFn;
  logic [RIDX_W-1:0] wrIdx;
  logic [DATA_W-1:0] wrVal;

  assign opcode  = ir[31:26];
  assign fieldRs = ir[25:21];
  assign fieldRt = ir[20:16];
  assign fieldRd = ir[15:11];
  assign fieldFn = ir[FN_W-1:0];

  assign immExt     = {{EXT_W{ir[IMM_W-1]}}, ir[IMM_W-1:0]};
  assign immShifted = {immExt[DATA_W-3:0], 2'b00};

  // program counter and instruction word
  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      ir <= '0;
    end else begin
      if (ctrl.pcLoad) begin
        pc <= aluY;
      end else if (ctrl.pcLoadIfEq && aluZero) begin
        pc <= aluOutQ;
      end
      if (ctrl.irLoad) begin
        ir <= memRdata;
      end
    end
  end

  // holding registers refreshed every cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
      mdrQ    <= '0;
    end else begin
      aQ      <= rfA;
      bQ      <= rfB;
      aluOutQ <= aluY;
      mdrQ    <= memRdata;
    end
  end

  assign srcAVal = ctrl.srcAIsReg ? aQ : pc;

  always_comb begin
    case (ctrl.srcB)
      SRCB_REG:   srcBVal = bQ;
      SRCB_FOUR:  srcBVal = DATA_W'(4);
      SRCB_IMM:   srcBVal = immExt;
      SRCB_IMMSH: srcBVal = immShifted;
      default:    srcBVal = bQ;
    endcase
  end

  always_comb begin
    case (ctrl.aluCtl)
      ACTL_ADD: aluOp = ALU_ADD;
      ACTL_SUB: aluOp = ALU_SUB;
      ACTL_FUNCT: begin
        case (fieldFn)
          FN_ADD:  aluOp = ALU_ADD;
          FN_SUB:  aluOp = ALU_SUB;
          FN_AND:  aluOp = ALU_AND;
          FN_OR:   aluOp = ALU_OR;
          FN_SLT:  aluOp = ALU_SLT;
          default: aluOp = ALU_ADD;
        endcase
      end
      default: aluOp = ALU_ADD;
    endcase
  end

  mc_alu #(.DATA_W(DATA_W)) uAlu (
    .opA    (srcAVal),
    .opB    (srcBVal),
    .op     (aluOp),
    .result (aluY),
    .isZero (aluZero)
  );

  assign wrIdx = ctrl.dstIsRd ? fieldRd : fieldRt;
  assign wrVal = ctrl.wbFromMdr ? mdrQ : aluOutQ;

  mc_regfile #(.DATA_W(DATA_W), .ENTRIES(REG_CNT)) uRegs (
    .clk     (clk),
    .rdAddrA (fieldRs),
    .rdAddrB (fieldRt),
    .rdDataA (rfA),
    .rdDataB (rfB),
    .wrEn    (ctrl.regWrite),
    .wrAddr  (wrIdx),
    .wrData  (wrVal)
  );

  assign memAddr  = ctrl.addrFromAlu ? aluOutQ : pc;
  assign memWdata = bQ;
  assign memWe    = ctrl.memWrite;

endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input  logic              clk,
  input  logic              rst,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] pcOut,
  output logic              retired
);

  ctrlT             ctrlBus;
  stateT            ctlState;
  logic [OPC_W-1:0] opcode;

  mc_control uCtl (
    .clk    (clk),
    .rst    (rst),
    .opcode (opcode),
    .ctrl   (ctrlBus),
    .state  (ctlState)
  );

  mc_datapath #(.DATA_W(DATA_W)) uDp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrlBus),
    .opcode   (opcode),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRdata (memRdata),
    .pc       (pcOut)
  );

  assign retired = ctrlBus.retire;

endmodule

// File: rtl/mc_core_chk.sv
module mc_core_chk
  import mc_pkg::*;
#(
  parameter int DATA_W = XLEN
) (
  input logic              clk,
  input logic              rst,
  input stateT             state,
  input logic [DATA_W-1:0] pcOut,
  input logic              memWe,
  input logic              retired
);

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (state == S_FETCH && pcOut == '0 && !memWe));

  a_r2_fetch_advance: assert property (@(posedge clk) disable iff (rst)
    state == S_FETCH |=> (state == S_DECODE && pcOut == $past(pcOut) + DATA_W'(4)));

  a_r2_pc_aligned: assert property (@(posedge clk) disable iff (rst)
    pcOut[1:0] == 2'b00);

  a_r7_pc_hold: assert property (@(posedge clk) disable iff (rst)
    !(state == S_FETCH || state == S_BRANCH) |=> $stable(pcOut));

  a_r6_store_after_addr: assert property (@(posedge clk) disable iff (rst)
    memWe |-> $past(state) == S_ADDR);

  a_r3_branch_path: assert property (@(posedge clk) disable iff (rst)
    state == S_BRANCH |-> ($past(state, 1) == S_DECODE && $past(state, 2) == S_FETCH));

  a_r10_retire_then_fetch: assert property (@(posedge clk) disable iff (rst)
    retired |=> (state == S_FETCH && !retired));

endmodule

bind mc_core mc_core_chk #(.DATA_W(DATA_W)) uChk (
  .clk     (clk),
  .rst     (rst),
  .state   (ctlState),
  .pcOut   (pcOut),
  .memWe   (memWe),
  .retired (retired)
);

// File: tb/tb_mc_core.sv
module tb_mc_core;

  localparam int MEM_WORDS = 256;
  localparam int NVEC      = 8;
  localparam int RUN_LIMIT = 400;

  localparam logic [5:0] OP_LW  = 6'h23;
  localparam logic [5:0] OP_SW  = 6'h2B;
  localparam logic [5:0] OP_BQ  = 6'h04;
  localparam logic [5:0] OP_BAD = 6'h3F;

  typedef struct packed {
    logic [5:0]  fn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vecT;

  localparam vecT VECS [NVEC] = '{
    '{6'h20, 32'd5,        32'd7,        32'd12},
    '{6'h20, 32'hFFFFFFFF, 32'd1,        32'd0},
    '{6'h22, 32'd3,        32'd5,        32'hFFFFFFFE},
    '{6'h24, 32'hF0F0A5A5, 32'h0FF0FF00, 32'h00F0A500},
    '{6'h25, 32'hF0000001, 32'h00F00010, 32'hF0F00011},
    '{6'h2A, 32'hFFFFFFFF, 32'd1,        32'd1},
    '{6'h2A, 32'd1,        32'hFFFFFFFF, 32'd0},
    '{6'h2A, 32'd9,        32'd9,        32'd0}
  };

  logic        clk;
  logic        rst;
  logic [31:0] memAddr;
  logic [31:0] memWdata;
  logic        memWe;
  logic [31:0] memRdata;
  logic [31:0] pcOut;
  logic        retired;

  logic [31:0] mem [MEM_WORDS];

  int checks;
  int fails;
  int retLog [8];
  int weCnt;
  logic [31:0] weAddr;

  mc_core dut (
    .clk      (clk),
    .rst      (rst),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .memWe    (memWe),
    .memRdata (memRdata),
    .pcOut    (pcOut),
    .retired  (retired)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  assign memRdata = mem[memAddr[9:2]];

  always @(posedge clk) begin
    if (memWe) mem[memAddr[9:2]] <= memWdata;
  end

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic holdReset();
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < MEM_WORDS; i++) mem[i] = 32'h0;
  endtask

  task automatic releaseReset();
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic runRetires(input int n);
    int k;
    int cyc;
    k = 0;
    cyc = 0;
    weCnt = 0;
    weAddr = '0;
    for (int i = 0; i < 8; i++) retLog[i] = -1;
    while (k < n && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
      if (memWe) begin
        weCnt++;
        weAddr = memAddr;
      end
      if (retired) begin
        retLog[k] = cyc;
        k++;
      end
    end
    if (k < n) check(1'b0, "R10", "run limit reached", 32'(k), 32'(n));
  endtask

  task automatic checkRetires(input int n, input int expLog [8], input string req);
    for (int i = 0; i < n; i++) begin
      check(retLog[i] == expLog[i], req, "completion cycle", 32'(retLog[i]), 32'(expLog[i]));
    end
  endtask

  task automatic loadArithProg(input vecT v);
    mem[0]  = encI(OP_LW, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(OP_LW, 5'd0, 5'd2, 16'h0104);
    mem[2]  = encR(5'd1, 5'd2, 5'd3, v.fn);
    mem[3]  = encI(OP_SW, 5'd0, 5'd3, 16'h0108);
    mem[4]  = encI(OP_BQ, 5'd0, 5'd0, 16'hFFFF);
    mem[64] = v.a;
    mem[65] = v.b;
    mem[66] = 32'hDEADBEEF;
  endtask

  // global watchdog
  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int arithLog [8];
    checks = 0;
    fails = 0;
    rst = 1'b1;
    arithLog = '{4, 9, 13, 17, 20, 0, 0, 0};

    // R1: reset state
    holdReset();
    loadArithProg(VECS[0]);
    releaseReset();
    check(pcOut == 32'h0,   "R1", "pc after reset", pcOut, 32'h0);
    check(memAddr == 32'h0, "R1", "fetch address after reset", memAddr, 32'h0);
    check(!memWe,           "R1", "write enable after reset", {31'h0, memWe}, 32'h0);
    check(!retired,         "R1", "completion after reset", {31'h0, retired}, 32'h0);

    // R1: reset in the middle of an instruction
    runRetires(1);
    @(negedge clk);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(pcOut == 32'h0, "R1", "pc after mid-run reset", pcOut, 32'h0);
    check(!memWe,         "R1", "write enable in reset", {31'h0, memWe}, 32'h0);
    rst = 1'b0;

    // R4, R3, R10: vector table of register-register operations
    for (int v = 0; v < NVEC; v++) begin
      holdReset();
      loadArithProg(VECS[v]);
      releaseReset();
      runRetires(5);
      check(mem[66] == VECS[v].exp, "R4", "arith result", mem[66], VECS[v].exp);
      checkRetires(5, arithLog, "R3_R10");
    end

    // R2: fetch step address and pc advance
    holdReset();
    loadArithProg(VECS[0]);
    releaseReset();
    @(negedge clk);
    check(pcOut == 32'h4, "R2", "pc after first fetch", pcOut, 32'h4);

    // R5, R6: negative load offset and single-cycle store
    holdReset();
    mem[0]  = encI(OP_LW, 5'd0, 5'd2, 16'h0100);
    mem[1]  = encI(OP_LW, 5'd2, 5'd1, 16'hFFFC);
    mem[2]  = encI(OP_SW, 5'd0, 5'd1, 16'h0110);
    mem[3]  = encI(OP_BQ, 5'd0, 5'd0, 16'hFFFF);
    mem[64] = 32'h0000010C;
    mem[66] = 32'hCAFEF00D;
    releaseReset();
    runRetires(3);
    @(negedge clk);
    check(mem[68] == 32'hCAFEF00D, "R5", "load with negative offset", mem[68], 32'hCAFEF00D);
    check(weCnt == 1,              "R6", "write enable cycles", 32'(weCnt), 32'd1);
    check(weAddr == 32'h110,       "R6", "store address", weAddr, 32'h110);
    check(retLog[2] - retLog[1] == 4, "R3", "store length", 32'(retLog[2] - retLog[1]), 32'd4);

    // R8: register 0 discards writes
    holdReset();
    mem[0]  = encI(OP_LW, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(OP_LW, 5'd0, 5'd2, 16'h0104);
    mem[2]  = encR(5'd1, 5'd2, 5'd0, 6'h20);
    mem[3]  = encI(OP_SW, 5'd0, 5'd0, 16'h0108);
    mem[4]  = encI(OP_LW, 5'd0, 5'd0, 16'h0100);
    mem[5]  = encI(OP_SW, 5'd0, 5'd0, 16'h010C);
    mem[6]  = encI(OP_BQ, 5'd0, 5'd0, 16'hFFFF);
    mem[64] = 32'h12345678;
    mem[65] = 32'h00000011;
    mem[66] = 32'hDEADBEEF;
    mem[67] = 32'hDEADBEEF;
    releaseReset();
    runRetires(6);
    @(negedge clk);
    check(mem[66] == 32'h0, "R8", "r0 after arith write", mem[66], 32'h0);
    check(mem[67] == 32'h0, "R8", "r0 after load", mem[67], 32'h0);

    // R7: branch taken forward
    holdReset();
    mem[0]  = encI(OP_LW, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(OP_LW, 5'd0, 5'd2, 16'h0104);
    mem[2]  = encI(OP_BQ, 5'd1, 5'd2, 16'h0003);
    mem[64] = 32'd7;
    mem[65] = 32'd7;
    releaseReset();
    runRetires(3);
    check(retLog[2] == 12, "R3", "branch completion cycle", 32'(retLog[2]), 32'd12);
    @(negedge clk);
    check(pcOut == 32'd24, "R7", "taken forward target", pcOut, 32'd24);

    // R7: branch not taken
    holdReset();
    mem[0]  = encI(OP_LW, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(OP_LW, 5'd0, 5'd2, 16'h0104);
    mem[2]  = encI(OP_BQ, 5'd1, 5'd2, 16'h0003);
    mem[64] = 32'd7;
    mem[65] = 32'd8;
    releaseReset();
    runRetires(3);
    @(negedge clk);
    check(pcOut == 32'd12, "R7", "not taken fall-through", pcOut, 32'd12);

    // R7: branch taken backward
    holdReset();
    mem[0]  = encI(OP_LW, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(OP_LW, 5'd0, 5'd2, 16'h0104);
    mem[2]  = encI(OP_BQ, 5'd0, 5'd0, 16'hFFFD);
    releaseReset();
    runRetires(3);
    @(negedge clk);
    check(pcOut == 32'd0, "R7", "taken backward target", pcOut, 32'd0);

    // R9: unknown opcode is a two-cycle no-op
    holdReset();
    mem[0]  = encI(OP_LW, 5'd0, 5'd1, 16'h0100);
    mem[1]  = encI(OP_BAD, 5'd0, 5'd1, 16'h0104);
    mem[2]  = encI(OP_SW, 5'd0, 5'd1, 16'h0108);
    mem[3]  = encI(OP_BQ, 5'd0, 5'd0, 16'hFFFF);
    mem[64] = 32'h11111111;
    mem[65] = 32'h22222222;
    releaseReset();
    runRetires(3);
    @(negedge clk);
    check(retLog[1] == 6,          "R9", "no-op completion cycle", 32'(retLog[1]), 32'd6);
    check(retLog[2] == 10,         "R3", "store after no-op", 32'(retLog[2]), 32'd10);
    check(mem[66] == 32'h11111111, "R9", "register unchanged by no-op", mem[66], 32'h11111111);
    check(mem[65] == 32'h22222222, "R9", "memory unchanged by no-op", mem[65], 32'h22222222);
    check(weCnt == 1,              "R9", "only the store writes", 32'(weCnt), 32'd1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule